// File: doc/BRIEF.md
# Group Completion Tracker

The tracker follows in-flight work at the granularity of dispatch groups. Each group has up to five instruction slots. Each accepted dispatch takes one entry of a circular table and records a mask of the occupied slots. The entry's index becomes the group's tag. Execution units later report each finished instruction by tag and slot index. Reports may arrive in any order and on any cycle, and the tracker never stalls them. It records them in a per-entry done mask.

The oldest group retires when every occupied slot has reported. Retirement frees the entry and produces a one-cycle retire indication carrying the tag. Groups retire strictly oldest first, one per cycle at most. A report that names a free entry, an unoccupied or out-of-range slot, or a slot that has already reported raises an error flag and changes nothing.

The default table of sixteen groups covers a completion latency of eight to ten cycles with room to spare. Dispatch is refused while the table is full.

Top module: `grp_cmpl_tracker`

## Requirements
- R1: During and after reset, `empty`=1, `full`=0, `disp_ready`=1, `ret_valid`=0, `cmp_err`=0 and `disp_tag`=0.
- R2: Tags are given out in dispatch order as table indices 0,1,...,15 and then wrap to 0. `disp_tag` always shows the tag that the next accepted dispatch will receive.
- R3: After 16 groups are held with none retired, `full`=1 and `disp_ready`=0. A dispatch attempted while full is ignored: `full` stays 1 and `disp_tag` is unchanged.
- R4: A group retires only after every slot whose mask bit is 1 has reported. `ret_valid` rises in the cycle after the clock edge that records the last report, with `ret_tag` equal to that group's tag.
- R5: Completion reports are accepted on every cycle with no ready signal, in any order, including reverse program order. Every group dispatched eventually retires once it is complete.
- R6: A complete group never retires while an older group is still incomplete.
- R7: Groups that are complete back to back retire on consecutive cycles, one per cycle, with ascending tags.
- R8: `cmp_err` is 1 in the cycle after a report that names an unallocated tag, a slot whose mask bit is 0, a slot index of 5 to 7, or a slot already reported. It is 0 after a valid report. An erroneous report does not count as a completion.
- R9: A group dispatched with an all-zero mask counts as complete at once and retires as soon as it is the oldest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | A group is offered for dispatch |
| disp_mask | input | SLOTS | Occupied slots of the offered group, bit i for slot i |
| disp_ready | output | 1 | Table can take a group this cycle |
| disp_tag | output | log2(DEPTH) | Tag the next accepted group receives |
| cmp_valid | input | 1 | A completion report is present |
| cmp_tag | input | log2(DEPTH) | Group tag of the report |
| cmp_slot | input | log2(SLOTS) | Slot index of the report |
| cmp_err | output | 1 | Previous cycle's report was invalid |
| ret_valid | output | 1 | Oldest group retires at the coming edge |
| ret_tag | output | log2(DEPTH) | Tag of the oldest group |
| full | output | 1 | All entries are in use |
| empty | output | 1 | No entry is in use |

## Verification
Dispatch and completion land at one clock edge. `ret_valid`, `ret_tag`, `full`, `empty` and `disp_tag` show the new state straight after that edge with no further latency, and `cmp_err` is registered, so it belongs to the report of the cycle before. The bench drives each stimulus just after a rising edge and reads `cmp_err` just after the edge that follows. It reads the retire outputs at the falling edge of that same cycle, and then at each later falling edge when it checks back-to-back retirement. A scoreboard queue holds the tags in dispatch order. At every falling edge where `ret_valid` is high it pops the next tag and checks it against `ret_tag`. It also checks that the bench's own count of outstanding reports for that group is zero.

// File: rtl/gct_pkg.sv
// Package: shared types for the group completion tracker.
// Assumes nothing beyond IEEE 1800-2017 packages.
package gct_pkg;

    // Outcome of checking one completion report against the table.
    typedef enum logic [1:0] {
        CHK_OK      = 2'd0,
        CHK_UNALLOC = 2'd1,
        CHK_BADSLOT = 2'd2,
        CHK_DUP     = 2'd3
    } chk_e;

endpackage

// File: rtl/gct_ring_ptr.sv
// Module: head/tail pointers and occupancy count of the group table.
// Assumes the caller never pushes when full and never pops when empty.
module gct_ring_ptr #(
    parameter int DEPTH = 16,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

    logic [TAG_W-1:0] head_q, tail_q;
    logic [TAG_W:0]   count_q;

    // Advance the pointers with wrap at DEPTH and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
            if (pop)  head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Derive the flow-control flags from the count.
    always_comb begin
        head  = head_q;
        tail  = tail_q;
        full  = (count_q == (TAG_W+1)'(DEPTH));
        empty = (count_q == '0);
    end
endmodule

// File: rtl/gct_slot_bank.sv
// Module: per-group storage of the live bit, valid-slot mask and done mask.
// Classifies each completion report and flags whether the head group is complete.
// Assumes the allocated and freed entries differ whenever both happen in one cycle.
module gct_slot_bank
    import gct_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SLOTS = 5,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  logic [SLOTS-1:0]  alloc_mask,
    input  logic              free_en,
    input  logic [TAG_W-1:0]  free_idx,
    input  logic              rep_en,
    input  logic [TAG_W-1:0]  rep_idx,
    input  logic [SLOT_W-1:0] rep_slot,
    input  logic [TAG_W-1:0]  head_idx,
    output chk_e              rep_chk,
    output logic              head_done
);
    logic             live_v [DEPTH];
    logic [SLOTS-1:0] mask_v [DEPTH];
    logic [SLOTS-1:0] done_v [DEPTH];
    logic [SLOTS-1:0] slot_oh;
    logic             rep_ok;

    // One-hot of the reported slot; indices of SLOTS and above decode to zero.
    assign slot_oh = SLOTS'(1) << rep_slot;
    assign rep_ok  = rep_en && (rep_chk == CHK_OK);

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic             live_r;
        logic [SLOTS-1:0] mask_r;
        logic [SLOTS-1:0] done_r;

        // Per-entry state: set up on dispatch, mark reports, release on retire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_r <= 1'b0;
                mask_r <= '0;
                done_r <= '0;
            end else if (alloc_en && alloc_idx == TAG_W'(e)) begin
                live_r <= 1'b1;
                mask_r <= alloc_mask;
                done_r <= '0;
            end else begin
                if (free_en && free_idx == TAG_W'(e)) live_r <= 1'b0;
                if (rep_ok && rep_idx == TAG_W'(e))   done_r <= done_r | slot_oh;
            end
        end

        assign live_v[e] = live_r;
        assign mask_v[e] = mask_r;
        assign done_v[e] = done_r;
    end

    // Classify the incoming report against the addressed entry.
    always_comb begin
        if (!live_v[rep_idx])                     rep_chk = CHK_UNALLOC;
        else if ((mask_v[rep_idx] & slot_oh) == '0) rep_chk = CHK_BADSLOT;
        else if ((done_v[rep_idx] & slot_oh) != '0) rep_chk = CHK_DUP;
        else                                      rep_chk = CHK_OK;
    end

    // The head group is complete when its done mask equals its valid mask.
    assign head_done = live_v[head_idx] && (done_v[head_idx] == mask_v[head_idx]);
endmodule

// File: rtl/grp_cmpl_tracker.sv
// Module: group completion tracker top. Allocates one table entry per
// dispatched group, records out-of-order slot completions and retires the
// oldest group, one per cycle at most, once all its occupied slots report.
// Assumes reports always arrive (no back-pressure) and SLOTS is at least 2.
module grp_cmpl_tracker
    import gct_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SLOTS = 5,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [SLOTS-1:0]  disp_mask,
    output logic              disp_ready,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic              cmp_valid,
    input  logic [TAG_W-1:0]  cmp_tag,
    input  logic [SLOT_W-1:0] cmp_slot,
    output logic              cmp_err,
    output logic              ret_valid,
    output logic [TAG_W-1:0]  ret_tag,
    output logic              full,
    output logic              empty
);
    logic [TAG_W-1:0] head, tail;
    logic             push, pop, head_done;
    chk_e             rep_chk;

    assign push = disp_valid && !full;
    assign pop  = !empty && head_done;

    gct_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .full  (full),
        .empty (empty)
    );

    gct_slot_bank #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (push),
        .alloc_idx  (tail),
        .alloc_mask (disp_mask),
        .free_en    (pop),
        .free_idx   (head),
        .rep_en     (cmp_valid),
        .rep_idx    (cmp_tag),
        .rep_slot   (cmp_slot),
        .head_idx   (head),
        .rep_chk    (rep_chk),
        .head_done  (head_done)
    );

    // Register the error flag for any report the bank rejected.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_err <= 1'b0;
        else        cmp_err <= cmp_valid && (rep_chk != CHK_OK);
    end

    // Drive the dispatch and retire side outputs.
    always_comb begin
        disp_ready = !full;
        disp_tag   = tail;
        ret_valid  = pop;
        ret_tag    = head;
    end
endmodule

// File: rtl/gct_checker.sv
// Module: property checker for the group completion tracker, bound to every
// instance of the top. Assumes the same parameters as the bound instance.
module gct_checker #(
    parameter int DEPTH = 16,
    parameter int SLOTS = 5,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_valid,
    input logic [SLOTS-1:0]  disp_mask,
    input logic              disp_ready,
    input logic [TAG_W-1:0]  disp_tag,
    input logic              cmp_valid,
    input logic [TAG_W-1:0]  cmp_tag,
    input logic [SLOT_W-1:0] cmp_slot,
    input logic              cmp_err,
    input logic              ret_valid,
    input logic [TAG_W-1:0]  ret_tag,
    input logic              full,
    input logic              empty
);
    localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

    // R1: the table is never both full and empty
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R2: an accepted dispatch advances the next tag by one, with wrap
    a_r2_tag_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=>
            disp_tag == (($past(disp_tag) == LAST) ? '0 : $past(disp_tag) + 1'b1));

    // R3: a full table without a retire stays full
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !ret_valid) |=> full);

    // R6: the oldest group does not move until it retires
    a_r6_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_valid && !empty) |=> ret_tag == $past(ret_tag));

    // R7: back-to-back retires carry consecutive tags
    a_r7_ret_order: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (!ret_valid ||
            ret_tag == (($past(ret_tag) == LAST) ? '0 : $past(ret_tag) + 1'b1)));

    // R8: a report while nothing is allocated is flagged
    a_r8_err_unalloc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && empty) |=> cmp_err);
endmodule

bind grp_cmpl_tracker gct_checker #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_chk (.*);

// File: tb/grp_cmpl_tracker_test.sv
`timescale 1ns/1ps
// Bench: scoreboard test of the group completion tracker.
module grp_cmpl_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid = 1'b0;
    logic [4:0] disp_mask = '0;
    logic       disp_ready;
    logic [3:0] disp_tag;
    logic       cmp_valid = 1'b0;
    logic [3:0] cmp_tag = '0;
    logic [2:0] cmp_slot = '0;
    logic       cmp_err;
    logic       ret_valid;
    logic [3:0] ret_tag;
    logic       full;
    logic       empty;

    int total = 0;
    int bad = 0;
    logic [3:0] exp_q[$];
    int model_left [16];
    int held = 0;
    logic [3:0] next_tag = '0;

    grp_cmpl_tracker uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_mask(disp_mask),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_slot(cmp_slot),
        .cmp_err(cmp_err), .ret_valid(ret_valid), .ret_tag(ret_tag),
        .full(full), .empty(empty)
    );

    // 125 MHz clock
    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: one cycle of optional dispatch and optional report, called just after a rising edge.
    task automatic cyc(input logic dv, input logic [4:0] m, input logic cv,
                       input logic [3:0] ct, input logic [2:0] cs,
                       input logic xerr, input string req);
        bit xready;
        xready = (held < 16);
        disp_valid = dv; disp_mask = m;
        cmp_valid = cv; cmp_tag = ct; cmp_slot = cs;
        #1;
        if (dv) begin
            chk(disp_ready == xready, "R3", "disp_ready", disp_ready, xready);
            if (xready) begin
                chk(disp_tag == next_tag, "R2", "disp_tag", disp_tag, next_tag);
                exp_q.push_back(next_tag);
                model_left[next_tag] = $countones(m);
                next_tag = next_tag + 1'b1;
                held++;
            end
        end
        if (cv && !xerr) model_left[ct]--;
        @(posedge clk); #1;
        disp_valid = 1'b0; cmp_valid = 1'b0;
        if (cv) chk(cmp_err == xerr, req, "cmp_err", cmp_err, xerr);
        else    chk(cmp_err == 1'b0, "R8", "cmp_err idle", cmp_err, 0);
    endtask

    // Check the retire outputs at the next falling edge.
    task automatic peek(input logic xv, input logic [3:0] xt, input string req);
        @(negedge clk);
        chk(ret_valid == xv, req, "ret_valid", ret_valid, xv);
        if (xv) chk(ret_tag == xt, req, "ret_tag", ret_tag, xt);
    endtask

    task automatic resync();
        @(posedge clk); #1;
    endtask

    // Monitor: pop the scoreboard on each retire and compare.
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6", "retire with nothing expected", ret_tag, -1);
            end else begin
                chk(ret_tag == exp_q[0], "R6", "retire order", ret_tag, exp_q[0]);
                chk(model_left[ret_tag] == 0, "R4", "slots left at retire",
                    model_left[ret_tag], 0);
                void'(exp_q.pop_front());
                held--;
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model_left[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(empty == 1'b1 && full == 1'b0, "R1", "flags in reset", {empty, full}, 2);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(empty == 1'b1, "R1", "empty", empty, 1);
        chk(full == 1'b0, "R1", "full", full, 0);
        chk(disp_ready == 1'b1, "R1", "disp_ready", disp_ready, 1);
        chk(ret_valid == 1'b0, "R1", "ret_valid", ret_valid, 0);
        chk(cmp_err == 1'b0, "R1", "cmp_err", cmp_err, 0);
        chk(disp_tag == 4'd0, "R1", "disp_tag", disp_tag, 0);

        // R4: group 0 with slots 0,2,4 retires only after the last report
        cyc(1, 5'b10101, 0, 0, 0, 0, "R2");
        cyc(0, 0, 1, 4'd0, 3'd4, 0, "R5");
        peek(0, 0, "R4");
        resync();
        cyc(0, 0, 1, 4'd0, 3'd0, 0, "R5");
        peek(0, 0, "R4");
        resync();
        cyc(0, 0, 1, 4'd0, 3'd2, 0, "R4");
        peek(1, 4'd0, "R4");
        resync();
        chk(empty == 1'b1, "R4", "empty after retire", empty, 1);

        // R8: error cases
        cyc(0, 0, 1, 4'd0, 3'd0, 1, "R8");
        cyc(1, 5'b00011, 0, 0, 0, 0, "R2");
        cyc(0, 0, 1, 4'd1, 3'd2, 1, "R8");
        cyc(0, 0, 1, 4'd1, 3'd5, 1, "R8");
        cyc(0, 0, 1, 4'd1, 3'd0, 0, "R8");
        peek(0, 0, "R8");
        resync();
        cyc(0, 0, 1, 4'd1, 3'd0, 1, "R8");
        peek(0, 0, "R8");
        resync();
        cyc(0, 0, 1, 4'd1, 3'd1, 0, "R8");
        peek(1, 4'd1, "R8");
        resync();

        // R6 and R7: younger groups wait, then retire back to back
        cyc(1, 5'b00001, 0, 0, 0, 0, "R2");
        cyc(1, 5'b00001, 0, 0, 0, 0, "R2");
        cyc(1, 5'b00011, 0, 0, 0, 0, "R2");
        cyc(0, 0, 1, 4'd4, 3'd1, 0, "R5");
        cyc(0, 0, 1, 4'd4, 3'd0, 0, "R5");
        cyc(0, 0, 1, 4'd3, 3'd0, 0, "R5");
        peek(0, 0, "R6");
        resync();
        cyc(0, 0, 1, 4'd2, 3'd0, 0, "R7");
        peek(1, 4'd2, "R7");
        peek(1, 4'd3, "R7");
        peek(1, 4'd4, "R7");
        peek(0, 0, "R7");
        resync();

        // R9: an empty-mask group retires straight away
        cyc(1, 5'b00000, 0, 0, 0, 0, "R9");
        peek(1, 4'd5, "R9");
        resync();

        // R3 and R2: fill the table across the tag wrap
        for (int i = 0; i < 16; i++) cyc(1, 5'b00001, 0, 0, 0, 0, "R2");
        chk(full == 1'b1, "R3", "full", full, 1);
        chk(disp_ready == 1'b0, "R3", "disp_ready", disp_ready, 0);
        cyc(1, 5'b00001, 0, 0, 0, 0, "R3");
        chk(full == 1'b1, "R3", "full after refused dispatch", full, 1);
        chk(disp_tag == 4'd6, "R3", "disp_tag after refused dispatch", disp_tag, 6);

        // R5: reports in reverse order on consecutive cycles
        for (int i = 0; i < 15; i++) begin
            logic [3:0] t;
            t = 4'(5 - i);
            cyc(0, 0, 1, t, 3'd0, 0, "R5");
        end
        chk(full == 1'b1, "R6", "full while head incomplete", full, 1);
        cyc(0, 0, 1, 4'd6, 3'd0, 0, "R5");
        repeat (20) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R5", "groups left unretired", exp_q.size(), 0);
        chk(empty == 1'b1, "R5", "empty after drain", empty, 1);
        cyc(1, 5'b00001, 0, 0, 0, 0, "R2");
        chk(disp_tag == 4'd7, "R2", "tag after wrap", disp_tag, 7);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule